// File: doc/BRIEF.md
# Segment Wait-State Bus Cycle Controller

This block times every access to a set of external memory or expansion segments that share an SRAM-like bus. Each segment carries its own small configuration record. The record holds the data width (8, 16 or 32 bits), a page-mode enable, a wait count for random (non-sequential) cycles and a wait count for burst (sequential) cycles. An access arrives as a request with a segment index, a read/write flag, a sequential flag and 32 bits of write data. The controller then drives the output-enable or write strobe and holds it for the programmed number of wait cycles. When the segment is narrower than 32 bits, it cuts the word into beats. At the end it raises a one-cycle done pulse with the assembled read word.

Configuration is written through a plain register port, one byte per segment. The controller takes a copy of the selected segment's record when it accepts an access and uses that copy for the whole access, so a reprogrammed segment changes behaviour only from its next access. Address decoding and card-specific interfaces are left to neighbouring logic. The `bus_beat` output gives the low address bits for each beat.

Top module: `seg_wait_ctrl`

## Requirements
- R1: After reset both strobes are high (inactive), `busy`, `done` and `rd_data` are zero, and every segment holds the configuration byte 0xFA: 32-bit width, page mode off, non-sequential code 7, burst code 3.
- R2: A configuration byte has this layout: bits [1:0] width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), bit [2] page enable, bits [5:3] non-sequential code, bits [7:6] burst wait count. A write with `cfg_we` high stores it into the segment named by `cfg_sel`.
- R3: A beat that uses the non-sequential count has code n and keeps its strobe low for n+2 cycles, which is n+1 wait states (1 to 8).
- R4: A beat uses the burst count (0 to 3 wait states, strobe low for count+1 cycles) only when page mode is enabled and either the beat is not the first or the request was flagged sequential. With a burst count of 0, each such beat completes in one cycle.
- R5: A 32-bit access becomes 1, 2 or 4 beats on a 32-, 16- or 8-bit segment, least significant part first. `bus_beat` gives the beat index, and `bus_wdata` carries the current write lane in its low bits.
- R6: On a read, the low lane bits of `bus_rdata` in the last strobe cycle of each beat are stored at lane position beat × width of `rd_data`. The upper bus bits on narrow segments are ignored.
- R7: `done` is high for exactly one cycle, N+1 rising edges after the accepting edge, where N is the total strobe-low cycle count. `rd_data` holds the full word in that cycle.
- R8: A read drives only `bus_oe_n` low and a write drives only `bus_we_n` low. The strobe stays low for every cycle of the access, across beat boundaries, and both strobes are high whenever `busy` is low.
- R9: An access uses the configuration in force at its accepting edge. A configuration write made during the access affects only later accesses.
- R10: A request is ignored, with no strobe, no `busy` and no `done`, when its segment index is 6 or more or when an access is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Segment whose configuration is written |
| cfg_wdata | input | 8 | Configuration byte |
| req | input | 1 | Access request, taken while idle |
| req_seg | input | 3 | Segment index of the request |
| req_seq | input | 1 | Request continues a sequential burst |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Assembled read word |
| bus_oe_n | output | 1 | Output enable strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_beat | output | 2 | Index of the current beat |
| bus_wdata | output | 32 | Write lane for the current beat |
| bus_rdata | input | 32 | Read data from the bus |

## Verification
The bench sweeps every combination of width, page enable, non-sequential code and burst count, each with reads and writes, flagged sequential and not. This separates the first-beat rule from the later-beat rule, and the page-on case from the page-off case. The bus model fills the unused upper bits with ones and moves each lane according to the reported beat index, so a wrong beat order, a wrong lane position or use of the wrong bits shows up as a data mismatch. Separate runs cover a configuration rewritten mid-access, a request while busy, an out-of-range segment, and width code 3. Each of these checks that the cycle counts and the strobes follow the copy of the configuration taken at acceptance.

// File: rtl/segws_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the segment wait-state controller.
// Assumes one configuration byte per segment with a fixed field layout.
package segws_pkg;

    localparam int CFG_W  = 8;
    localparam int WAIT_W = 4;

    typedef enum logic [1:0] {
        BW_8   = 2'd0,
        BW_16  = 2'd1,
        BW_32  = 2'd2,
        BW_32X = 2'd3
    } bus_width_e;

    // Packed MSB first: [7:6] burst count, [5:3] random code, [2] page, [1:0] width
    typedef struct packed {
        logic [1:0] seq_wait;
        logic [2:0] nseq_code;
        logic       page_en;
        bus_width_e width;
    } seg_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    localparam seg_cfg_t CFG_RESET = '{seq_wait: 2'd3, nseq_code: 3'd7,
                                       page_en: 1'b0, width: BW_32};

    // Wait cycles for one beat: burst count or random code plus one.
    function automatic logic [WAIT_W-1:0] beat_wait(input seg_cfg_t c, input logic use_seq);
        if (use_seq)
            return {2'b00, c.seq_wait};
        return {1'b0, c.nseq_code} + 4'd1;
    endfunction

    // Index of the final beat for the segment width.
    function automatic logic [1:0] last_beat(input seg_cfg_t c);
        case (c.width)
            BW_8:    return 2'd3;
            BW_16:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/segws_cfg_regs.sv
`timescale 1ns/1ps
// Per-segment configuration register file.
// Holds one byte per segment, written through a simple port and read
// combinationally by segment index. Writes to an index past the last
// segment are dropped; out-of-range reads return the reset value.
module segws_cfg_regs
    import segws_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEL_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic [SEL_W-1:0]     rd_sel,
    output seg_cfg_t             rd_cfg
);

    seg_cfg_t regs [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        seg_cfg_t r;

        // Store the configuration byte for this segment.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= CFG_RESET;
            else if (wr_en && (int'(wr_sel) == g))
                r <= seg_cfg_t'(wr_data);
        end

        assign regs[g] = r;
    end

    // Select the record of the requested segment.
    always_comb begin
        rd_cfg = CFG_RESET;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (int'(rd_sel) == i)
                rd_cfg = regs[i];
        end
    end

endmodule

// File: rtl/segws_wait_timer.sv
`timescale 1ns/1ps
// Down-counter that times the strobe cycles of one beat.
// A load sets the remaining wait count; expired is high in the final
// strobe cycle of the beat (count zero). Rests at zero when idle.
module segws_wait_timer
    import segws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);

    logic [WAIT_W-1:0] cnt;

    // Load a new beat or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/segws_lane_path.sv
`timescale 1ns/1ps
// Data lane steering for narrow segments.
// Drives the current write lane on the low bus bits and places each
// captured read lane at its position in the assembled word.
// Assumes DATA_W is divisible by four.
module segws_lane_path
    import segws_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_width_e        width,
    input  logic [1:0]        beat,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [DATA_W-1:0] bus_rd,
    input  logic              capture,
    output logic [DATA_W-1:0] bus_wr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int QW = DATA_W / 4;
    localparam int HW = DATA_W / 2;

    // Pick the write lane for the current beat.
    always_comb begin
        bus_wr = '0;
        case (width)
            BW_8:    bus_wr[QW-1:0] = wr_word[int'(beat) * QW +: QW];
            BW_16:   bus_wr[HW-1:0] = wr_word[int'(beat[0]) * HW +: HW];
            default: bus_wr = wr_word;
        endcase
    end

    // Merge the read lane of the finishing beat into the word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (capture) begin
            case (width)
                BW_8:    rd_word[int'(beat) * QW +: QW]    <= bus_rd[QW-1:0];
                BW_16:   rd_word[int'(beat[0]) * HW +: HW] <= bus_rd[HW-1:0];
                default: rd_word <= bus_rd;
            endcase
        end
    end

endmodule

// File: rtl/seg_wait_ctrl.sv
`timescale 1ns/1ps
// Segment wait-state bus cycle controller (top).
// Accepts one access at a time while idle, copies the segment's
// configuration, and runs one to four beats with programmed waits,
// strobe held low throughout. Raises done for one cycle afterwards.
// Assumes requesters hold off while busy; such requests are dropped.
module seg_wait_ctrl
    import segws_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int DATA_W  = 32,
    localparam int SEL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req,
    input  logic [SEL_W-1:0]  req_seg,
    input  logic              req_seq,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic [1:0]        bus_beat,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    ctl_state_e        state;
    seg_cfg_t          sel_cfg;
    seg_cfg_t          cur_cfg;
    logic              cur_wr;
    logic [DATA_W-1:0] cur_wdata;
    logic [1:0]        beat;
    logic              accept;
    logic              expired;
    logic              beat_end;
    logic              is_last;
    logic              tmr_load;
    logic [WAIT_W-1:0] tmr_val;
    logic [WAIT_W-1:0] first_wait;
    logic [WAIT_W-1:0] next_wait;

    segws_cfg_regs #(
        .NUM_SEG (NUM_SEG),
        .SEL_W   (SEL_W)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .rd_sel  (req_seg),
        .rd_cfg  (sel_cfg)
    );

    // Decide acceptance and the wait counts of first and later beats.
    always_comb begin
        accept     = req && (state == ST_IDLE) && (int'(req_seg) < NUM_SEG);
        first_wait = beat_wait(sel_cfg, sel_cfg.page_en && req_seq);
        next_wait  = beat_wait(cur_cfg, cur_cfg.page_en);
        beat_end   = (state == ST_RUN) && expired;
        is_last    = (beat == last_beat(cur_cfg));
        tmr_load   = accept || (beat_end && !is_last);
        tmr_val    = accept ? first_wait : next_wait;
    end

    segws_wait_timer timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    // Sequence idle and running states and track the beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_cfg   <= CFG_RESET;
            cur_wr    <= 1'b0;
            cur_wdata <= '0;
            beat      <= 2'd0;
            done      <= 1'b0;
        end else begin
            done <= beat_end && is_last;
            if (accept) begin
                state     <= ST_RUN;
                cur_cfg   <= sel_cfg;
                cur_wr    <= req_write;
                cur_wdata <= req_wdata;
                beat      <= 2'd0;
            end else if (beat_end) begin
                if (is_last)
                    state <= ST_IDLE;
                else
                    beat <= beat + 2'd1;
            end
        end
    end

    segws_lane_path #(
        .DATA_W (DATA_W)
    ) lane_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .width   (cur_cfg.width),
        .beat    (beat),
        .wr_word (cur_wdata),
        .bus_rd  (bus_rdata),
        .capture (beat_end && !cur_wr),
        .bus_wr  (bus_wdata),
        .rd_word (rd_data)
    );

    assign busy     = (state == ST_RUN);
    assign bus_oe_n = !(busy && !cur_wr);
    assign bus_we_n = !(busy && cur_wr);
    assign bus_beat = beat;

endmodule

// File: rtl/seg_wait_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for seg_wait_ctrl, attached by bind.
// Watches strobes, busy, done and requests at the ports only.
module seg_wait_ctrl_chk #(
    parameter int NUM_SEG  = 6,
    parameter int SEL_W    = 3,
    parameter int MAX_BUSY = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [SEL_W-1:0] req_seg,
    input logic             busy,
    input logic             done,
    input logic             bus_oe_n,
    input logic             bus_we_n
);

    logic [7:0] run_len;

    // Count consecutive busy cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (!busy)
            run_len <= '0;
        else if (run_len != 8'hFF)
            run_len <= run_len + 8'd1;
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_oe_n && bus_we_n));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R10
    bad_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && (int'(req_seg) >= NUM_SEG)) |=> !busy);

    // R3
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_len) <= MAX_BUSY);

endmodule

bind seg_wait_ctrl seg_wait_ctrl_chk #(
    .NUM_SEG (NUM_SEG),
    .SEL_W   (SEL_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_seg  (req_seg),
    .busy     (busy),
    .done     (done),
    .bus_oe_n (bus_oe_n),
    .bus_we_n (bus_we_n)
);

// File: tb/seg_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every segment configuration and checks
// cycle counts, strobes, lanes and read data against arithmetic models.
module seg_wait_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req = 1'b0;
    logic [2:0]  req_seg = '0;
    logic        req_seq = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, bus_oe_n, bus_we_n;
    logic [31:0] rd_data, bus_wdata, bus_rdata;
    logic [1:0]  bus_beat;

    logic [31:0] tb_pat = '0;
    int          tb_lw = 32;
    logic [31:0] tb_mask;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    seg_wait_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req(req), .req_seg(req_seg), .req_seq(req_seq),
        .req_write(req_write), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_beat(bus_beat), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Bus model: lane of the pattern on low bits, ones above.
    always_comb begin
        tb_mask   = (tb_lw >= 32) ? 32'hFFFF_FFFF : ((32'h1 << tb_lw) - 32'h1);
        bus_rdata = ((tb_pat >> (int'(bus_beat) * tb_lw)) & tb_mask) | ~tb_mask;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic write_cfg(input int sel, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel[2:0]; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_access(input int seg, input bit seq, input bit wr,
                             input logic [31:0] wd, input logic [31:0] pat,
                             input int wc, input bit page, input int nc,
                             input int sc, input string tag);
        int lw, nb, n, k, strobes, bad, done_k, expb, rem;
        int w[4];
        logic [31:0] m;
        lw = (wc == 0) ? 8 : (wc == 1) ? 16 : 32;
        nb = 32 / lw;
        m  = (lw == 32) ? 32'hFFFF_FFFF : ((32'h1 << lw) - 32'h1);
        n  = 0;
        for (int b = 0; b < 4; b++) begin
            w[b] = (page && (b > 0 || seq)) ? sc : nc + 1;
            if (b < nb) n += w[b] + 1;
        end
        @(negedge clk);
        req = 1'b1; req_seg = seg[2:0]; req_seq = seq; req_write = wr;
        req_wdata = wd; tb_pat = pat; tb_lw = lw;
        @(negedge clk);
        req = 1'b0;
        k = 1; strobes = 0; bad = 0; done_k = -1; expb = 0; rem = w[0];
        while (k <= 40) begin
            if (done) begin
                done_k = k;
                break;
            end
            if (!bus_oe_n || !bus_we_n) begin
                strobes++;
                if (wr ? !(bus_oe_n && !bus_we_n) : !(!bus_oe_n && bus_we_n)) bad++;
                if (int'(bus_beat) != expb) bad++;
                if (wr && ((bus_wdata & m) != ((wd >> (expb * lw)) & m))) bad++;
                if (rem == 0) begin
                    expb++;
                    if (expb < 4) rem = w[expb];
                end else begin
                    rem--;
                end
            end
            @(negedge clk);
            k++;
        end
        check(done_k == n + 1, {tag, "/R7"}, "done cycle", done_k, n + 1);
        check(strobes == n, tag, "strobe cycles", strobes, n);
        check(bad == 0, "R5/R8", "beat, lane or strobe errors", bad, 0);
        if (!wr) check(rd_data == pat, "R6", "read word", rd_data, pat);
        @(negedge clk);
        check(!done, "R7", "done longer than one cycle", done, 0);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ok;
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        check(bus_oe_n && bus_we_n, "R1", "strobes after reset", {bus_oe_n, bus_we_n}, 3);
        check(rd_data == 0, "R1", "rd_data after reset", rd_data, 0);
        // R1: default configuration, 32-bit with 8 waits
        do_access(2, 1'b1, 1'b0, 32'h0, 32'hA5C3_0F96, 2, 1'b0, 7, 3, "R1");

        // R2: width code 3 behaves as 32-bit
        write_cfg(1, {2'd0, 3'd0, 1'b0, 2'd3});
        do_access(1, 1'b0, 1'b0, 32'h0, 32'h1357_9BDF, 3, 1'b0, 0, 0, "R2");

        // R2/R3/R4/R5/R6: full configuration sweep
        idx = 0;
        for (int wc = 0; wc < 3; wc++)
            for (int pg = 0; pg < 2; pg++)
                for (int nc = 0; nc < 8; nc++)
                    for (int sc = 0; sc < 4; sc++) begin
                        write_cfg(idx % 6, {sc[1:0], nc[2:0], pg[0], wc[1:0]});
                        for (int sq = 0; sq < 2; sq++)
                            for (int wr = 0; wr < 2; wr++)
                                do_access(idx % 6, sq[0], wr[0],
                                          32'h9E37_79B9 * (idx + 1) + 32'h0102_0304 * sq,
                                          32'h6D2B_79F5 * (idx + 3) + 32'h1111 * wr,
                                          wc, pg[0], nc, sc, (pg != 0) ? "R4" : "R3");
                        idx++;
                    end

        // R4: zero-wait page beats on an 8-bit segment
        write_cfg(5, {2'd0, 3'd5, 1'b1, 2'd0});
        do_access(5, 1'b1, 1'b0, 32'h0, 32'hDEAD_BEEF, 0, 1'b1, 5, 0, "R4");

        // R9: configuration rewritten during an access
        write_cfg(0, {2'd0, 3'd2, 1'b0, 2'd0});
        fork
            do_access(0, 1'b0, 1'b0, 32'h0, 32'h0BAD_F00D, 0, 1'b0, 2, 0, "R9");
            begin
                repeat (4) @(negedge clk);
                write_cfg(0, {2'd0, 3'd0, 1'b0, 2'd0});
            end
        join
        do_access(0, 1'b0, 1'b0, 32'h0, 32'hCAFE_1234, 0, 1'b0, 0, 0, "R9");

        // R10: request while busy is dropped
        write_cfg(3, {2'd0, 3'd4, 1'b0, 2'd1});
        fork
            do_access(3, 1'b0, 1'b0, 32'h0, 32'h8765_4321, 1, 1'b0, 4, 0, "R10");
            begin
                repeat (5) @(negedge clk);
                req = 1'b1; req_seg = 3'd3; req_write = 1'b1;
                @(negedge clk);
                req = 1'b0;
            end
        join
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (busy || done || !bus_oe_n || !bus_we_n) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R10", "activity after request during busy", !ok, 0);

        // R10: out-of-range segment index is dropped
        @(negedge clk);
        req = 1'b1; req_seg = 3'd6; req_write = 1'b0;
        @(negedge clk);
        req = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (busy || done || !bus_oe_n || !bus_we_n) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R10", "activity for segment 6", !ok, 0);
        @(negedge clk);
        req = 1'b1; req_seg = 3'd7;
        @(negedge clk);
        req = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (busy || done || !bus_oe_n || !bus_we_n) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R10", "activity for segment 7", !ok, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule